// File: doc/BRIEF.md
# Receive Line Clock Recovery Loop

This block recovers bit timing from a serial line stream that has already been sliced into logic levels. It runs from a 7.68 MHz reference clock. The line carries 192 kbit/s, so one bit lasts 40 reference cycles. A phase counter marks the expected bit boundary at phase 0 and the receive sampling point at mid-bit, phase 20. Each data transition is compared with the expected boundary. Once per bit the loop moves its phase by a single reference cycle toward the transition. When the line is quiet the counter free-runs and keeps its last phase.

A transmit bit strobe is taken from the recovered phase. It lags the receive bit boundary by two whole bit periods plus a coarse trim chosen by a 2-bit select. A lock flag reports whether recent transitions have stayed close to the expected boundary. Slicing, level detection, line coding, framing and PCM clocks are handled elsewhere.

Top module: `line_dpll`

## Requirements
- R1: While `rstN` is low, and in the first cycle after its release, `rxStrobe`, `txStrobe`, `rxData` and `lineLocked` are all 0.
- R2: The phase counter starts at 0 after reset and steps once per clock through 0..39. `rxStrobe` is high for one cycle whenever the phase is 20. With no line transitions, `rxStrobe` fires every 40 cycles, the first time in the 21st cycle after reset.
- R3: Take a transition, seen two cycles after it enters on `rxLine` at phase p. If p is in 1..20, the next bit is stretched by one cycle because phase 39 is held for two cycles. If p is in 21..39, the next bit is shortened by one cycle because the step from 38 goes to 0. If p is 0 there is no correction. At most one correction is applied per bit, and the latest transition decides it.
- R4: `rxData` takes the two-cycle-delayed line level present in the cycle of each `rxStrobe`, and shows it from the next cycle.
- R5: `txStrobe` fires once per bit, when the phase equals the trim and the phase is not being held. The trim is 0 cycles for `compSel` 00, 2 for 01 (260 ns), 4 for 10 (520 ns) and 8 for 11 (1040 ns). It stays silent for the first two bit periods after reset, which gives the two-bit lag.
- R6: A bit hits when its first transition lands at phase 0..2 or 37..39. `lineLocked` rises at the end of the 16th consecutive hit bit.
- R7: A bit misses when its first transition falls outside that window. `lineLocked` falls at the end of the 8th consecutive miss bit. A miss clears the hit run, and a hit clears the miss run.
- R8: Bits with no transition leave the hit run, the miss run and `lineLocked` unchanged.
- R9: Successive `rxStrobe` pulses are always 39, 40 or 41 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 7.68 MHz reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxLine | input | 1 | Sliced receive line level |
| compSel | input | 2 | Transmit delay trim select |
| rxStrobe | output | 1 | Receive mid-bit sampling strobe |
| rxData | output | 1 | Recovered receive bit |
| txStrobe | output | 1 | Transmit bit strobe |
| lineLocked | output | 1 | Loop lock indication |

## Verification
The in-line assertions check several rules on every cycle: the phase never leaves 0..39, no bit is stretched by more than one cycle, and receive strobes are never closer than 39 or further than 41 cycles apart. They also check that the lock flag changes only when a hit or miss run reaches its threshold. Other behaviour shows up only in the bench scenarios, which drive a cycle-level model in step with the design: the direction of each correction for late or early transitions, convergence onto a stream with an offset or a wrong rate, the exact cycle of the transmit strobe for each trim, and lock holding across a silent line and dropping after a phase jump.

// File: rtl/dpll_pkg.sv
package dpll_pkg;
  typedef enum logic [1:0] {
    ADJ_NONE = 2'd0,
    ADJ_ADV  = 2'd1,
    ADJ_RET  = 2'd2
  } adj_e;

  typedef struct packed {
    logic hold;
    logic skip;
  } phaseCtl_t;
endpackage

// File: rtl/dpll_datapath.sv
module dpll_datapath
  import dpll_pkg::*;
#(
  parameter int BIT_CYCLES = 40,
  parameter int PW = 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          rxLine,
  input  phaseCtl_t     ctl,
  output logic [PW-1:0] phase,
  output logic          edgeDet,
  output logic          rxStrobe,
  output logic          rxData
);
  localparam logic [PW-1:0] LAST_P = PW'(BIT_CYCLES - 1);
  localparam logic [PW-1:0] MID_P  = PW'(BIT_CYCLES / 2);
  localparam int GW = $clog2(BIT_CYCLES + 4);

  logic rxQ, rxD, rxDataR;

  assign edgeDet  = rxQ ^ rxD;
  assign rxStrobe = (phase == MID_P);
  assign rxData   = rxDataR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxQ     <= 1'b0;
      rxD     <= 1'b0;
      rxDataR <= 1'b0;
      phase   <= '0;
    end else begin
      rxQ <= rxLine;
      rxD <= rxQ;
      if (rxStrobe) rxDataR <= rxQ;
      if (ctl.hold)                        phase <= phase;
      else if (ctl.skip || phase == LAST_P) phase <= '0;
      else                                 phase <= phase + 1'b1;
    end
  end

  // Strobe spacing monitor
  logic [GW-1:0] gapCnt;
  logic          seenStrobe;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gapCnt     <= '0;
      seenStrobe <= 1'b0;
    end else if (rxStrobe) begin
      gapCnt     <= '0;
      seenStrobe <= 1'b1;
    end else if (gapCnt != '1) begin
      gapCnt <= gapCnt + 1'b1;
    end
  end

  p_phase_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    phase <= LAST_P);

  p_one_stretch_r3: assert property (@(posedge clk) disable iff (!rstN)
    (phase == LAST_P && $past(phase) == LAST_P) |-> $past(phase, 2) != LAST_P);

  p_strobe_gap_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rxStrobe && seenStrobe) |-> (int'(gapCnt) >= BIT_CYCLES - 2 && int'(gapCnt) <= BIT_CYCLES));
endmodule

// File: rtl/dpll_control.sv
module dpll_control
  import dpll_pkg::*;
#(
  parameter int BIT_CYCLES = 40,
  parameter int PW = 6,
  parameter int COMP_STEP = 2,
  parameter int TOL = 2,
  parameter int HIT_N = 16,
  parameter int MISS_N = 8,
  parameter int TX_LAG = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [PW-1:0] phase,
  input  logic          edgeDet,
  input  logic [1:0]    compSel,
  output phaseCtl_t     ctl,
  output logic          txStrobe,
  output logic          locked
);
  localparam logic [PW-1:0] LAST_P = PW'(BIT_CYCLES - 1);
  localparam logic [PW-1:0] MID_P  = PW'(BIT_CYCLES / 2);
  localparam logic [PW-1:0] LO_P   = PW'(TOL);
  localparam logic [PW-1:0] HI_P   = PW'(BIT_CYCLES - 1 - TOL);
  localparam int HW = $clog2(HIT_N + 1);
  localparam int MW = $clog2(MISS_N + 1);
  localparam int BW = $clog2(TX_LAG + 1);

  adj_e          pend;
  logic          firstSeen, firstHit;
  logic [HW-1:0] hitCnt;
  logic [MW-1:0] missCnt;
  logic [BW-1:0] bitsDone;
  logic          bitEnd, edgeHit, seenNow, hitNow, txArmed;
  logic [PW-1:0] compCycles;

  assign ctl.hold = (phase == LAST_P) && (pend == ADJ_RET);
  assign ctl.skip = (phase == LAST_P - 1'b1) && (pend == ADJ_ADV);
  assign bitEnd   = ((phase == LAST_P) && !ctl.hold) || ctl.skip;
  assign edgeHit  = (phase <= LO_P) || (phase >= HI_P);
  assign seenNow  = firstSeen || edgeDet;
  assign hitNow   = firstSeen ? firstHit : edgeHit;
  assign txArmed  = (bitsDone == BW'(TX_LAG));

  always_comb begin
    case (compSel)
      2'b01:   compCycles = PW'(COMP_STEP);
      2'b10:   compCycles = PW'(2 * COMP_STEP);
      2'b11:   compCycles = PW'(4 * COMP_STEP);
      default: compCycles = '0;
    endcase
  end

  assign txStrobe = txArmed && (phase == compCycles) && !ctl.hold;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pend <= ADJ_NONE;
    end else if (edgeDet) begin
      if (phase == '0)         pend <= ADJ_NONE;
      else if (phase <= MID_P) pend <= ADJ_RET;
      else                     pend <= ADJ_ADV;
    end else if (ctl.hold || ctl.skip) begin
      pend <= ADJ_NONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      firstSeen <= 1'b0;
      firstHit  <= 1'b0;
      hitCnt    <= '0;
      missCnt   <= '0;
      locked    <= 1'b0;
      bitsDone  <= '0;
    end else if (bitEnd) begin
      firstSeen <= 1'b0;
      if (!txArmed) bitsDone <= bitsDone + 1'b1;
      if (seenNow) begin
        if (hitNow) begin
          missCnt <= '0;
          if (hitCnt != HW'(HIT_N)) hitCnt <= hitCnt + 1'b1;
          if (hitCnt == HW'(HIT_N - 1)) locked <= 1'b1;
        end else begin
          hitCnt <= '0;
          if (missCnt != MW'(MISS_N)) missCnt <= missCnt + 1'b1;
          if (missCnt == MW'(MISS_N - 1)) locked <= 1'b0;
        end
      end
    end else if (edgeDet && !firstSeen) begin
      firstSeen <= 1'b1;
      firstHit  <= edgeHit;
    end
  end

  p_lock_rise_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> $past(hitCnt) == HW'(HIT_N - 1));

  p_lock_fall_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(locked) |-> $past(missCnt) == MW'(MISS_N - 1));

  p_tx_silent_r5: assert property (@(posedge clk) disable iff (!rstN)
    (phase == '0 && $past(phase) == '0) |-> !txStrobe || $past(txArmed));
endmodule

// File: rtl/line_dpll.sv
module line_dpll
  import dpll_pkg::*;
#(
  parameter int BIT_CYCLES = 40,
  parameter int COMP_STEP = 2,
  parameter int TOL = 2,
  parameter int HIT_N = 16,
  parameter int MISS_N = 8,
  parameter int TX_LAG = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxLine,
  input  logic [1:0] compSel,
  output logic       rxStrobe,
  output logic       rxData,
  output logic       txStrobe,
  output logic       lineLocked
);
  localparam int PW = $clog2(BIT_CYCLES);

  phaseCtl_t     ctl;
  logic [PW-1:0] phase;
  logic          edgeDet;

  dpll_datapath #(.BIT_CYCLES(BIT_CYCLES), .PW(PW)) u_path (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .ctl(ctl),
    .phase(phase), .edgeDet(edgeDet), .rxStrobe(rxStrobe), .rxData(rxData)
  );

  dpll_control #(
    .BIT_CYCLES(BIT_CYCLES), .PW(PW), .COMP_STEP(COMP_STEP), .TOL(TOL),
    .HIT_N(HIT_N), .MISS_N(MISS_N), .TX_LAG(TX_LAG)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .phase(phase), .edgeDet(edgeDet),
    .compSel(compSel), .ctl(ctl), .txStrobe(txStrobe), .locked(lineLocked)
  );
endmodule

// File: tb/line_dpll_test.sv
module line_dpll_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxLine = 1'b0;
  logic [1:0] compSel = 2'b00;
  logic rxStrobe, rxData, txStrobe, lineLocked;

  int errors = 0;
  int checks = 0;
  int cycle = 0;
  bit done = 0;

  line_dpll uut (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .compSel(compSel),
    .rxStrobe(rxStrobe), .rxData(rxData), .txStrobe(txStrobe), .lineLocked(lineLocked)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cycle, act, exp);
    end
  endtask

  // Behavioural reference model, written from the requirements
  int mPh, mQ, mD, mData, mPend, mSeen, mHit1, mHitRun, mMissRun, mLock, mBits;
  function automatic int trimOf(input logic [1:0] s);
    int t[4] = '{0, 2, 4, 8};
    return t[s];
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPh = 0; mQ = 0; mD = 0; mData = 0; mPend = 0; mSeen = 0; mHit1 = 0;
      mHitRun = 0; mMissRun = 0; mLock = 0; mBits = 0;
    end else begin
      int edg, hold, skip, endBit, hitE, seenN, hitN;
      edg    = (mQ != mD);
      hold   = (mPh == 39 && mPend == 2);
      skip   = (mPh == 38 && mPend == 1);
      endBit = (mPh == 39 && !hold) || skip;
      hitE   = (mPh <= 2 || mPh >= 37);
      seenN  = mSeen || edg;
      hitN   = mSeen ? mHit1 : hitE;
      if (mPh == 20) mData = mQ;
      if (edg) mPend = (mPh == 0) ? 0 : (mPh <= 20 ? 2 : 1);
      else if (hold || skip) mPend = 0;
      if (endBit) begin
        mSeen = 0;
        if (mBits < 2) mBits++;
        if (seenN) begin
          if (hitN) begin
            mMissRun = 0; mHitRun++;
            if (mHitRun >= 16) mLock = 1;
          end else begin
            mHitRun = 0; mMissRun++;
            if (mMissRun >= 8) mLock = 0;
          end
        end
      end else if (edg && !mSeen) begin
        mSeen = 1; mHit1 = hitE;
      end
      mD = mQ;
      mQ = rxLine;
      if (hold) mPh = mPh;
      else if (skip || mPh == 39) mPh = 0;
      else mPh++;
    end
  end

  // Line generator
  bit genOn = 0;
  bit randMode = 0;
  int genPeriod = 40;
  int genCnt = 0;
  logic [7:0] lfsr = 8'hA5;
  always @(negedge clk) begin
    genCnt++;
    if (genCnt >= genPeriod) begin
      genCnt = 0;
      if (genOn) begin
        if (randMode) begin
          lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
          rxLine <= lfsr[0];
        end else begin
          rxLine <= ~rxLine;
        end
      end
    end
  end

  // Per-cycle comparison and strobe spacing
  int lastStrobe = -1;
  always @(negedge clk) begin
    cycle++;
    if (rstN && !done) begin
      int eTx;
      eTx = (mBits >= 2) && (mPh == trimOf(compSel)) && !(mPh == 39 && mPend == 2);
      check("R2 R3 rxStrobe", int'(rxStrobe), int'(mPh == 20));
      check("R4 rxData", int'(rxData), mData);
      check("R5 txStrobe", int'(txStrobe), eTx);
      check("R6 R7 lineLocked", int'(lineLocked), mLock);
      if (rxStrobe) begin
        if (lastStrobe >= 0)
          check("R9 strobe spacing ok", int'((cycle - lastStrobe) >= 39 && (cycle - lastStrobe) <= 41), 1);
        lastStrobe = cycle;
      end
    end
    if (cycle > 150000 && !done) begin
      done = 1;
      check("watchdog", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic waitBits(input int n);
    repeat (n * 40) @(negedge clk);
  endtask

  task automatic setComp(input logic [1:0] s);
    @(posedge clk); #1 compSel = s;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rxStrobe in reset", int'(rxStrobe), 0);
    check("R1 txStrobe in reset", int'(txStrobe), 0);
    check("R1 rxData in reset", int'(rxData), 0);
    check("R1 lineLocked in reset", int'(lineLocked), 0);
    @(posedge clk); #2 rstN = 1'b1;
    @(negedge clk);
    check("R1 first cycle idle", int'(rxStrobe | txStrobe | lineLocked), 0);
    // R2: free run on a silent line
    waitBits(10);
    check("R8 no lock on silent line", int'(lineLocked), 0);
    // R3 R6: late-offset alternating stream, loop converges and locks
    genCnt = 28;
    genOn = 1;
    waitBits(45);
    check("R6 locked after convergence", int'(lineLocked), 1);
    // R4 R5: random data, each trim
    randMode = 1;
    setComp(2'b01); waitBits(12);
    setComp(2'b10); waitBits(12);
    setComp(2'b11); waitBits(12);
    setComp(2'b00);
    // R8: silent line keeps lock
    genOn = 0;
    waitBits(30);
    check("R8 lock held through silence", int'(lineLocked), 1);
    // R7: phase jump of half a bit
    randMode = 0;
    genCnt = (genCnt + 20) % 40;
    genOn = 1;
    waitBits(14);
    check("R7 lock lost after jump", int'(lineLocked), 0);
    // R3 R9: rate offsets
    genPeriod = 41; waitBits(40);
    genPeriod = 39; waitBits(40);
    genPeriod = 40; randMode = 1; waitBits(30);
    check("R6 relocked at nominal rate", int'(lineLocked), 1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule